// File: doc/BRIEF.md
# Multimode Asynchronous Serial Receiver

This block receives asynchronous serial frames in the style of a classic microcontroller serial port. It has three framed modes. One carries eight data bits. Two carry nine data bits: one of them runs at a fixed fraction of the core clock, and the other is paced by an external 16x oversampling tick. The block finds the start bit, takes every bit as a 2-of-3 vote from three samples around mid-bit, and shifts the data in LSB first. It presents the byte, a separate ninth bit and a receive-complete flag to the surrounding register logic.

Software deals with the block through sticky flags: receive-complete, framing error, break and overrun. Each flag has its own clear strobe. In a multiprocessor network the address filter drops 9-bit frames whose ninth bit is 0, so a node is only interrupted by address frames until it has been selected. Error flags can optionally share the receive interrupt. The interrupt can also be merged with a transmit-done flag supplied from outside.

Top module: `uart_mrx`

## Requirements
- R1: `frame_mode` picks the frame. 2'b01 gives start, 8 data bits and stop. 2'b10 and 2'b11 give start, 9 data bits and stop. With 2'b00 no frame is received and `rx_done` stays 0.
- R2: Each bit lasts 16 sample points. In mode 2'b10 a sample is taken every clock when `fix_rate_x2`=1 (16 clocks per bit) and every second clock when it is 0 (32 clocks per bit). In modes 2'b01 and 2'b11 a sample is taken on each `os_tick` pulse.
- R3: Bits are sampled at sample points 7, 8 and 9 of the bit, counting the first low sample of the start bit as point 0, and a 2-of-3 majority decides the value. A start bit that votes high is dropped and the receiver returns to idle.
- R4: Data arrive LSB first on `rx_data`. In the 9-bit modes the ninth bit appears on `rx_bit9`. In mode 2'b01, `rx_bit9` takes the value of the stop bit.
- R5: While `rx_enable` is 0, no new frame is started, so `rx_done` and `rx_data` do not change.
- R6: In the 9-bit modes with `addr_filter`=1, a frame whose ninth bit is 0 neither sets `rx_done` nor changes `rx_data`. In mode 2'b01 the filter has no effect.
- R7: `frame_err` is set when the stop bit votes low. It stays set through later valid frames until `clr_frame_err`.
- R8: `break_det` is set after 11 consecutive bit times (176 samples) of low line. Ten low bit times do not set it. It clears only on `clr_break`.
- R9: `overrun` is set when the last data bit of a frame that passes the filter is sampled while `rx_done` is still 1. The new byte replaces the held one.
- R10: `irq` is 1 whenever `rx_done` is 1. `frame_err`, `break_det` and `overrun` drive `irq` only while `err_irq_en`=1.
- R11: With `irq_rx_only`=0, `tx_flag` also drives `irq`. With `irq_rx_only`=1, `tx_flag` has no effect on `irq`.
- R12: Each clear strobe clears only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_serial | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | 16x oversampling tick for modes 2'b01 and 2'b11 |
| frame_mode | input | 2 | Mode select |
| fix_rate_x2 | input | 1 | Mode 2'b10 rate: 1 = clock/16, 0 = clock/32 |
| rx_enable | input | 1 | Allows new frames to start |
| addr_filter | input | 1 | Multiprocessor address filter enable |
| err_irq_en | input | 1 | Lets error flags raise the interrupt |
| irq_rx_only | input | 1 | 1 = interrupt excludes `tx_flag` |
| tx_flag | input | 1 | Transmit-done flag from the transmitter |
| clr_rx_done | input | 1 | Clears `rx_done` |
| clr_frame_err | input | 1 | Clears `frame_err` |
| clr_break | input | 1 | Clears `break_det` |
| clr_overrun | input | 1 | Clears `overrun` |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Ninth bit, or stop bit in 8-bit mode |
| rx_done | output | 1 | Receive-complete flag |
| frame_err | output | 1 | Framing error flag |
| break_det | output | 1 | Break flag |
| overrun | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions hold these rules: the receiver stays idle while reception is disabled or the mode is 2'b00; the framing and break flags stay set until their strobes; an overrun only arises while `rx_done` is set; a filtered frame leaves the data output alone; and `rx_done` always shows on `irq`. Other behaviour can only be seen by driving whole frames. That covers the bit order, the placement of the ninth or stop bit, the sampling rates of each mode, majority rejection of a short start pulse, the 10- versus 11-bit-time break threshold, overwrite on overrun and the interrupt masking options. The bench drives those frames. It sweeps every byte value in the fast fixed-rate mode and a spread of bytes in the other modes.

// File: rtl/uart_mrx_pkg.sv
package uart_mrx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] MODE_SHIFT = 2'b00;
  localparam logic [1:0] MODE_8BIT  = 2'b01;
  localparam logic [1:0] MODE_9FIX  = 2'b10;
  localparam logic [1:0] MODE_9VAR  = 2'b11;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_mrx_sync.sv
module uart_mrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q, chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_n;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_mrx_tick.sv
module uart_mrx_tick
  import uart_mrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       rate_x2,
  input  logic       ext_tick,
  output logic       samp_en
);
  logic half_q, half_n;

  always_comb begin
    half_n = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_n;
  end

  always_comb begin
    unique case (mode)
      MODE_9FIX:  samp_en = rate_x2 | half_q;
      MODE_SHIFT: samp_en = 1'b0;
      default:    samp_en = ext_tick;
    endcase
  end
endmodule

// File: rtl/uart_mrx_break.sv
module uart_mrx_break #(
  parameter int OVS      = 16,
  parameter int BRK_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en,
  input  logic line,
  output logic brk_hit
);
  localparam int THR  = OVS * BRK_BITS;
  localparam int CW   = $clog2(THR + 1);
  localparam logic [CW-1:0] THR_C  = CW'(THR);
  localparam logic [CW-1:0] LAST_C = CW'(THR - 1);

  logic [CW-1:0] low_q, low_n;

  always_comb begin
    low_n   = low_q;
    brk_hit = 1'b0;
    if (samp_en) begin
      if (line) begin
        low_n = '0;
      end else if (low_q != THR_C) begin
        low_n = low_q + 1'b1;
        if (low_q == LAST_C) brk_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else        low_q <= low_n;
  end
endmodule

// File: rtl/uart_mrx_frame.sv
module uart_mrx_frame
  import uart_mrx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic              line,
  input  logic [1:0]        mode,
  input  logic              rx_enable,
  output logic              frame_done,
  output logic              frame_stop,
  output logic              frame_ninth,
  output logic [DATA_W-1:0] frame_data,
  output logic              last_pulse,
  output logic              last_val
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] TICK_A   = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] TICK_B   = CNT_W'(OVS/2);
  localparam logic [CNT_W-1:0] TICK_C   = CNT_W'(OVS/2 + 1);
  localparam logic [CNT_W-1:0] TICK_END = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST8 = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_NINE  = IDX_W'(DATA_W);

  rx_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] shreg_q, shreg_n;
  logic              bit9_q, bit9_n;
  logic              smp_a_q, smp_a_n;
  logic              smp_b_q, smp_b_n;
  logic              nine_mode, vote;
  logic [IDX_W-1:0]  idx_last;

  always_comb begin
    nine_mode  = mode[1];
    idx_last   = nine_mode ? IDX_NINE : IDX_LAST8;
    vote       = maj3(smp_a_q, smp_b_q, line);
    state_n    = state_q;
    cnt_n      = cnt_q;
    idx_n      = idx_q;
    shreg_n    = shreg_q;
    bit9_n     = bit9_q;
    smp_a_n    = smp_a_q;
    smp_b_n    = smp_b_q;
    frame_done = 1'b0;
    last_pulse = 1'b0;
    if (samp_en) begin
      if (state_q == ST_IDLE) begin
        if (rx_enable && (mode != MODE_SHIFT) && !line) begin
          state_n = ST_START;
          cnt_n   = CNT_W'(1);
        end
      end else begin
        cnt_n = (cnt_q == TICK_END) ? '0 : cnt_q + 1'b1;
        if (cnt_q == TICK_A) smp_a_n = line;
        if (cnt_q == TICK_B) smp_b_n = line;
        if (cnt_q == TICK_C) begin
          unique case (state_q)
            ST_START: if (vote) state_n = ST_IDLE;
            ST_DATA: begin
              if (idx_q == IDX_NINE) bit9_n = vote;
              else                   shreg_n = {vote, shreg_q[DATA_W-1:1]};
              if (idx_q == idx_last) last_pulse = 1'b1;
            end
            ST_STOP: begin
              frame_done = 1'b1;
              state_n    = ST_IDLE;
            end
            default: ;
          endcase
        end
        if (cnt_q == TICK_END) begin
          if (state_q == ST_START) begin
            state_n = ST_DATA;
            idx_n   = '0;
          end else if (state_q == ST_DATA) begin
            if (idx_q == idx_last) state_n = ST_STOP;
            else                   idx_n   = idx_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      bit9_q  <= 1'b0;
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      shreg_q <= shreg_n;
      bit9_q  <= bit9_n;
      smp_a_q <= smp_a_n;
      smp_b_q <= smp_b_n;
    end
  end

  assign frame_stop  = vote;
  assign last_val    = vote;
  assign frame_ninth = nine_mode ? bit9_q : vote;
  assign frame_data  = shreg_q;

  // R5: a disabled receiver never leaves idle
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !rx_enable) |=> (state_q == ST_IDLE));

  // R1: shift-register mode receives nothing
  p_shift_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && mode == MODE_SHIFT) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/uart_mrx.sv
module uart_mrx
  import uart_mrx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int BRK_BITS    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_serial,
  input  logic              os_tick,
  input  logic [1:0]        frame_mode,
  input  logic              fix_rate_x2,
  input  logic              rx_enable,
  input  logic              addr_filter,
  input  logic              err_irq_en,
  input  logic              irq_rx_only,
  input  logic              tx_flag,
  input  logic              clr_rx_done,
  input  logic              clr_frame_err,
  input  logic              clr_break,
  input  logic              clr_overrun,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_done,
  output logic              frame_err,
  output logic              break_det,
  output logic              overrun,
  output logic              irq
);
  logic [1:0] rst_pipe_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int = rst_pipe_q[1];

  logic              line_s, samp_en, brk_hit;
  logic              frame_done, frame_stop, frame_ninth, last_pulse, last_val;
  logic [DATA_W-1:0] frame_data;

  uart_mrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int), .din(rx_serial), .dout(line_s));

  uart_mrx_tick u_tick (
    .clk(clk), .rst_n(rst_int), .mode(frame_mode), .rate_x2(fix_rate_x2),
    .ext_tick(os_tick), .samp_en(samp_en));

  uart_mrx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_int), .samp_en(samp_en), .line(line_s),
    .mode(frame_mode), .rx_enable(rx_enable), .frame_done(frame_done),
    .frame_stop(frame_stop), .frame_ninth(frame_ninth), .frame_data(frame_data),
    .last_pulse(last_pulse), .last_val(last_val));

  uart_mrx_break #(.OVS(OVS), .BRK_BITS(BRK_BITS)) u_break (
    .clk(clk), .rst_n(rst_int), .samp_en(samp_en), .line(line_s), .brk_hit(brk_hit));

  logic [DATA_W-1:0] data_q, data_n;
  logic bit9_q, bit9_n, done_q, done_n, fe_q, fe_n, brk_q, brk_n, ovr_q, ovr_n;
  logic nine_mode, keep_frame, ovr_hit;

  always_comb begin
    nine_mode  = frame_mode[1];
    keep_frame = frame_done && !(nine_mode && addr_filter && !frame_ninth);
    ovr_hit    = last_pulse && done_q && !(nine_mode && addr_filter && !last_val);
    data_n     = keep_frame ? frame_data  : data_q;
    bit9_n     = keep_frame ? frame_ninth : bit9_q;
    done_n     = keep_frame | (done_q & ~clr_rx_done);
    fe_n       = (frame_done & ~frame_stop) | (fe_q & ~clr_frame_err);
    brk_n      = brk_hit | (brk_q & ~clr_break);
    ovr_n      = ovr_hit | (ovr_q & ~clr_overrun);
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      data_q <= '0;
      bit9_q <= 1'b0;
      done_q <= 1'b0;
      fe_q   <= 1'b0;
      brk_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      bit9_q <= bit9_n;
      done_q <= done_n;
      fe_q   <= fe_n;
      brk_q  <= brk_n;
      ovr_q  <= ovr_n;
    end
  end

  assign rx_data   = data_q;
  assign rx_bit9   = bit9_q;
  assign rx_done   = done_q;
  assign frame_err = fe_q;
  assign break_det = brk_q;
  assign overrun   = ovr_q;
  assign irq       = done_q | (err_irq_en & (fe_q | brk_q | ovr_q)) | (~irq_rx_only & tx_flag);

  // R7: framing error is sticky until its strobe
  p_fe_sticky_r7: assert property (@(posedge clk) disable iff (!rst_int)
    (frame_err && !clr_frame_err) |=> frame_err);

  // R8: break flag is sticky until its strobe
  p_brk_sticky_r8: assert property (@(posedge clk) disable iff (!rst_int)
    (break_det && !clr_break) |=> break_det);

  // R9: overrun only rises while a frame is still held
  p_ovr_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(overrun) |-> $past(rx_done));

  // R6: a filtered frame leaves the data output alone
  p_filter_hold_r6: assert property (@(posedge clk) disable iff (!rst_int)
    (frame_done && nine_mode && addr_filter && !frame_ninth) |=> $stable(rx_data));

  // R10: a held frame always requests service
  p_rx_irq_r10: assert property (@(posedge clk) disable iff (!rst_int)
    rx_done |-> irq);
endmodule

// File: tb/tb_uart_mrx.sv
module tb_uart_mrx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_serial, os_tick;
  logic [1:0] frame_mode;
  logic       fix_rate_x2, rx_enable, addr_filter, err_irq_en, irq_rx_only, tx_flag;
  logic       clr_rx_done, clr_frame_err, clr_break, clr_overrun;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_done, frame_err, break_det, overrun, irq;

  int nchk = 0;
  int nerr = 0;
  int tdiv = 4;
  int tcnt = 0;
  logic [7:0] last_b;

  always #10 clk = ~clk;

  uart_mrx dut (
    .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial), .os_tick(os_tick),
    .frame_mode(frame_mode), .fix_rate_x2(fix_rate_x2), .rx_enable(rx_enable),
    .addr_filter(addr_filter), .err_irq_en(err_irq_en), .irq_rx_only(irq_rx_only),
    .tx_flag(tx_flag), .clr_rx_done(clr_rx_done), .clr_frame_err(clr_frame_err),
    .clr_break(clr_break), .clr_overrun(clr_overrun), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_done(rx_done), .frame_err(frame_err),
    .break_det(break_det), .overrun(overrun), .irq(irq));

  initial begin
    os_tick = 1'b0;
    forever begin
      @(negedge clk);
      tcnt++;
      if (tcnt >= tdiv) begin
        os_tick = 1'b1;
        tcnt    = 0;
      end else begin
        os_tick = 1'b0;
      end
    end
  end

  function automatic int bclk();
    if (frame_mode == 2'b10) return fix_rate_x2 ? 16 : 32;
    return 16 * tdiv;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rx_serial = v;
    repeat (bclk()) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] pay, input logic stopv);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(pay[i]);
    if (frame_mode[1]) drive_bit(pay[8]);
    drive_bit(stopv);
    rx_serial = 1'b1;
    repeat (2 * bclk()) @(negedge clk);
  endtask

  task automatic strobe(input logic d, input logic f, input logic b, input logic o);
    clr_rx_done = d; clr_frame_err = f; clr_break = b; clr_overrun = o;
    @(negedge clk);
    clr_rx_done = 1'b0; clr_frame_err = 1'b0; clr_break = 1'b0; clr_overrun = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_serial = 1'b1; frame_mode = 2'b01; fix_rate_x2 = 1'b0;
    rx_enable = 1'b1; addr_filter = 1'b0; err_irq_en = 1'b0; irq_rx_only = 1'b1;
    tx_flag = 1'b0; clr_rx_done = 1'b0; clr_frame_err = 1'b0; clr_break = 1'b0;
    clr_overrun = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("reset rx_data", 32'(rx_data), 0);
    check("reset rx_done", 32'(rx_done), 0);
    check("reset frame_err", 32'(frame_err), 0);
    check("reset break_det", 32'(break_det), 0);
    check("reset overrun", 32'(overrun), 0);
    check("reset irq", 32'(irq), 0);

    // R1 R2 R4: sweep of modes and rates
    for (int cfg = 0; cfg < 4; cfg++) begin
      int n;
      case (cfg)
        0: begin frame_mode = 2'b01; tdiv = 4; end
        1: begin frame_mode = 2'b10; fix_rate_x2 = 1'b0; end
        2: begin frame_mode = 2'b10; fix_rate_x2 = 1'b1; end
        default: begin frame_mode = 2'b11; tdiv = 3; end
      endcase
      n = (cfg == 2) ? 256 : 16;
      for (int i = 0; i < n; i++) begin
        logic [7:0] b;
        logic       nb;
        b  = (cfg == 2) ? 8'(i) : 8'((i * 37 + 11) & 255);
        nb = ^b;
        send_frame({nb, b}, 1'b1);
        check("R1 R2 R4 rx_data", 32'(rx_data), 32'(b));
        check("R1 R2 rx_done", 32'(rx_done), 1);
        check("R4 rx_bit9", 32'(rx_bit9), frame_mode[1] ? 32'(nb) : 1);
        check("R7 no frame_err", 32'(frame_err), 0);
        last_b = b;
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
      end
    end

    // R1: mode 00 receives nothing
    frame_mode = 2'b00; tdiv = 4;
    send_frame(9'h03C, 1'b1);
    check("R1 mode00 rx_done", 32'(rx_done), 0);
    check("R1 mode00 rx_data", 32'(rx_data), 32'(last_b));

    // R5: disabled receiver
    frame_mode = 2'b01; rx_enable = 1'b0;
    send_frame(9'h03C, 1'b1);
    check("R5 disabled rx_done", 32'(rx_done), 0);
    check("R5 disabled rx_data", 32'(rx_data), 32'(last_b));
    rx_enable = 1'b1;

    // R3: a start held low for 8 samples votes high and is dropped
    frame_mode = 2'b10; fix_rate_x2 = 1'b1;
    rx_serial = 1'b0;
    repeat (8) @(negedge clk);
    rx_serial = 1'b1;
    repeat (48) @(negedge clk);
    check("R3 short start rx_done", 32'(rx_done), 0);
    check("R3 short start break", 32'(break_det), 0);
    send_frame(9'h096, 1'b1);
    check("R3 after glitch rx_data", 32'(rx_data), 32'h96);
    check("R3 after glitch rx_done", 32'(rx_done), 1);
    strobe(1'b1, 1'b0, 1'b0, 1'b0);

    // R6: address filter
    frame_mode = 2'b11; tdiv = 3; addr_filter = 1'b1;
    send_frame(9'h055, 1'b1);
    check("R6 filtered rx_done", 32'(rx_done), 0);
    check("R6 filtered rx_data", 32'(rx_data), 32'h96);
    send_frame(9'h1AA, 1'b1);
    check("R6 address rx_done", 32'(rx_done), 1);
    check("R6 address rx_data", 32'(rx_data), 32'hAA);
    check("R6 address rx_bit9", 32'(rx_bit9), 1);
    strobe(1'b1, 1'b0, 1'b0, 1'b0);
    frame_mode = 2'b01; tdiv = 4;
    send_frame(9'h05A, 1'b1);
    check("R6 8-bit unfiltered rx_done", 32'(rx_done), 1);
    check("R6 8-bit unfiltered rx_data", 32'(rx_data), 32'h5A);
    strobe(1'b1, 1'b0, 1'b0, 1'b0);
    addr_filter = 1'b0;

    // R7 R8 R4: zero frame with low stop (10 low bit times)
    send_frame(9'h000, 1'b0);
    check("R7 frame_err set", 32'(frame_err), 1);
    check("R7 data loaded", 32'(rx_data), 0);
    check("R4 stop on rx_bit9", 32'(rx_bit9), 0);
    check("R8 ten low bits no break", 32'(break_det), 0);
    strobe(1'b1, 1'b0, 1'b0, 1'b0);
    send_frame(9'h033, 1'b1);
    check("R7 sticky frame_err", 32'(frame_err), 1);
    check("R7 valid data", 32'(rx_data), 32'h33);
    strobe(1'b0, 1'b1, 1'b0, 1'b0);
    check("R12 frame_err cleared", 32'(frame_err), 0);
    check("R12 rx_done kept", 32'(rx_done), 1);
    strobe(1'b1, 1'b0, 1'b0, 1'b0);

    // R8: 12 low bit times sets break
    frame_mode = 2'b10; fix_rate_x2 = 1'b1;
    rx_serial = 1'b0;
    repeat (12 * 16) @(negedge clk);
    rx_serial = 1'b1;
    repeat (16 * 16) @(negedge clk);
    check("R8 break set", 32'(break_det), 1);
    strobe(1'b1, 1'b1, 1'b0, 1'b1);
    check("R8 break held", 32'(break_det), 1);
    strobe(1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 break cleared", 32'(break_det), 0);

    // R9: overrun and overwrite
    frame_mode = 2'b01; tdiv = 4;
    send_frame(9'h011, 1'b1);
    check("R9 no overrun first", 32'(overrun), 0);
    send_frame(9'h022, 1'b1);
    check("R9 overrun set", 32'(overrun), 1);
    check("R9 overwrite", 32'(rx_data), 32'h22);
    strobe(1'b1, 1'b0, 1'b0, 1'b0);

    // R10 R11: interrupt masking with overrun held
    err_irq_en = 1'b0; irq_rx_only = 1'b1; tx_flag = 1'b0;
    @(negedge clk);
    check("R10 errors masked", 32'(irq), 0);
    err_irq_en = 1'b1;
    @(negedge clk);
    check("R10 errors enabled", 32'(irq), 1);
    err_irq_en = 1'b0; tx_flag = 1'b1; irq_rx_only = 1'b0;
    @(negedge clk);
    check("R11 combined tx", 32'(irq), 1);
    irq_rx_only = 1'b1;
    @(negedge clk);
    check("R11 rx only ignores tx", 32'(irq), 0);
    tx_flag = 1'b0;
    strobe(1'b0, 1'b0, 1'b0, 1'b1);
    check("R12 overrun cleared", 32'(overrun), 0);
    send_frame(9'h0C3, 1'b1);
    check("R10 rx_done drives irq", 32'(irq), 1);
    check("R12 no overrun after clear", 32'(overrun), 0);

    summary();
    $finish;
  end
endmodule